// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Reporting

The controller gathers 72 level-sensitive request lines and reports them to a processor through one small register window. The lines form two 32-bit peripheral banks, called A and B, and one 8-bit base bank. Each bank has its own mask. Software sets mask bits by writing ones to that bank's enable word and clears them by writing ones to its disable word. Masked status can be read per bank.

The base status word is the first place a handler looks. It carries the base bank's own lines, one summary flag per peripheral bank, and eleven shortcut flags. The shortcut flags mirror frequently used peripheral lines, so those lines can be identified with a single read. A line with a shortcut does not raise its bank's summary flag. It can be masked only in its own bank.

There is one fast-interrupt channel. Any one of the 72 lines can be steered to the `fiq_o` output, and a steered line is then kept off `irq_o`. Both outputs are registered.

Top module: `banked_intc`

## Requirements
- R1: After reset every mask bit is clear, the fast-interrupt control word at 0x0c reads 0, and `irq_o` and `fiq_o` are low.
- R2: A write to 0x10 (bank A), 0x14 (bank B) or 0x18 (base) sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. A read of the same offset returns the mask.
- R3: A write to 0x1c (A), 0x20 (B) or 0x24 (base) clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A read of 0x04 returns the bank A sources ANDed with the bank A mask, and a read of 0x08 does the same for bank B. These values follow the sources and are not latched. `rdata` is valid on the clock edge that samples `rd_en`.
- R5: In the base word at 0x00, bits 7:0 are the masked base sources. Bit 8 is set when any masked bank A line without a shortcut is pending, and bit 9 is the same for bank B. Bits 31:21 read 0.
- R6: Base bits 10 to 20 mirror, in this order, bank A lines 7, 9, 10, 18 and 19, then bank B lines 21, 22, 23, 24, 25 and 30, each after its own bank's mask. A pending shortcut line shows in both its bank word and the base word, and it does not set bit 8 or bit 9.
- R7: Only bits 7:0 of the base mask exist. Data bits 31:8 written to 0x18 or 0x24 have no effect, so a shortcut line cannot be masked or unmasked through the base words.
- R8: One cycle after the pending state changes, `irq_o` equals the OR of all masked pending lines, excluding any line steered to the fast channel.
- R9: In the word at 0x0c, bits 6:0 pick a line by combined index: bank A is 0–31, bank B is 32–63 and base is 64–71. Bit 7 enables the channel, and bits 7:0 read back. One cycle later, `fiq_o` is high when the channel is enabled and the selected line's raw level is high, whatever its mask. An index of 72 or above never asserts `fiq_o`.
- R10: While the channel is enabled, the selected line never contributes to `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_a | input | 32 | Bank A request levels |
| src_b | input | 32 | Bank B request levels |
| src_base | input | 8 | Base bank request levels |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |

## Verification
The hardest case to reach is a pending line that holds a shortcut while the base mask is written with every upper bit set. To get there, the bench unmasks bank A line 7 and bank B line 25 and drives only those two lines. It then checks that bits 8 and 9 of the base word stay clear while bits 10 and 19 rise. Next it masks line 7 in its bank and floods 0x18 and 0x24 with ones above bit 7, then confirms that neither the base mask readback nor the shortcut bit changes. The steering case drives a line that is both masked-in and selected for the fast channel, then adds a second line, so that `irq_o` is seen low and then high while `fiq_o` stays high.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // word index = byte offset / 4
  localparam logic [3:0] W_BASE_PEND = 4'd0;
  localparam logic [3:0] W_A_PEND    = 4'd1;
  localparam logic [3:0] W_B_PEND    = 4'd2;
  localparam logic [3:0] W_FIQ_CTL   = 4'd3;
  localparam logic [3:0] W_A_SET     = 4'd4;
  localparam logic [3:0] W_B_SET     = 4'd5;
  localparam logic [3:0] W_BASE_SET  = 4'd6;
  localparam logic [3:0] W_A_CLR     = 4'd7;
  localparam logic [3:0] W_B_CLR     = 4'd8;
  localparam logic [3:0] W_BASE_CLR  = 4'd9;

  localparam int unsigned SC_N = 11;

  // combined index (bank A 0..31, bank B 32..63) mirrored by shortcut k
  function automatic int unsigned sc_src(int unsigned k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 53;
      6: return 54;
      7: return 55;
      8: return 56;
      9: return 57;
      default: return 62;
    endcase
  endfunction
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((|set_i) && !(|clr_i)) |=> ((en_o & $past(set_i)) == $past(set_i)));
  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|clr_i) |=> ((en_o & $past(clr_i)) == '0));
endmodule

// File: rtl/intc_base_fmt.sv
module intc_base_fmt #(
  parameter int BANK_W = 32,
  parameter int BASE_W = 8
) (
  input  logic [BANK_W-1:0] pend_a,
  input  logic [BANK_W-1:0] pend_b,
  input  logic [BASE_W-1:0] pend_base,
  output logic [BANK_W-1:0] word_o
);
  localparam int SC_LO  = BASE_W + 2;
  localparam int SC_HI  = SC_LO + int'(intc_pkg::SC_N);
  localparam int PAIR_W = 2 * BANK_W;

  logic [PAIR_W-1:0] pair;
  logic [PAIR_W-1:0] sc_mask;
  logic [intc_pkg::SC_N-1:0] sc_bits;

  assign pair = {pend_b, pend_a};

  genvar k;
  generate
    for (k = 0; k < int'(intc_pkg::SC_N); k++) begin : g_sc
      localparam int SRC = int'(intc_pkg::sc_src(k));
      assign sc_bits[k] = pair[SRC];
      assign sc_mask[SRC] = 1'b1;
    end
    for (k = 0; k < PAIR_W; k++) begin : g_nosc
      localparam bit IS_SC = (k == 7) || (k == 9) || (k == 10) || (k == 18) ||
                             (k == 19) || (k == 53) || (k == 54) || (k == 55) ||
                             (k == 56) || (k == 57) || (k == 62);
      if (!IS_SC) begin : g_z
        assign sc_mask[k] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    word_o = '0;
    word_o[BASE_W-1:0]   = pend_base;
    word_o[BASE_W]       = |(pend_a & ~sc_mask[BANK_W-1:0]);
    word_o[BASE_W+1]     = |(pend_b & ~sc_mask[PAIR_W-1:BANK_W]);
    word_o[SC_HI-1:SC_LO] = sc_bits;
  end
endmodule

// File: rtl/intc_fiq_route.sv
module intc_fiq_route #(
  parameter int NSRC  = 72,
  parameter int IDX_W = 7
) (
  input  logic [NSRC-1:0]  src_i,
  input  logic [NSRC-1:0]  pend_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             on_i,
  output logic             irq_d,
  output logic             fiq_d
);
  logic [NSRC-1:0] steer;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_st
      assign steer[i] = on_i && (int'(sel_i) == i);
    end
  endgenerate

  assign irq_d = |(pend_i & ~steer);
  assign fiq_d = |(src_i & steer);
endmodule

// File: rtl/banked_intc.sv
module banked_intc #(
  parameter int BANK_W = 32,
  parameter int BASE_W = 8,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] rdata,
  input  logic [BANK_W-1:0] src_a,
  input  logic [BANK_W-1:0] src_b,
  input  logic [BASE_W-1:0] src_base,
  output logic              irq_o,
  output logic              fiq_o
);
  import intc_pkg::*;

  localparam int NSRC = 2 * BANK_W + BASE_W;

  logic [3:0] widx;
  assign widx = 4'(addr[ADDR_W-1:2]);

  logic [BANK_W-1:0] en_a, en_b, pend_a, pend_b, base_word;
  logic [BASE_W-1:0] en_base, pend_base;
  logic [IDX_W-1:0]  fiq_sel;
  logic              fiq_on;
  logic              irq_d, fiq_d;

  function automatic logic [BANK_W-1:0] strobe(logic [3:0] w);
    return (wr_en && widx == w) ? wdata : '0;
  endfunction

  logic [BANK_W-1:0] base_set_w, base_clr_w;
  assign base_set_w = strobe(W_BASE_SET);
  assign base_clr_w = strobe(W_BASE_CLR);

  intc_mask_bank #(.W(BANK_W)) u_mask_a (
    .clk(clk), .rst(rst), .set_i(strobe(W_A_SET)), .clr_i(strobe(W_A_CLR)), .en_o(en_a));
  intc_mask_bank #(.W(BANK_W)) u_mask_b (
    .clk(clk), .rst(rst), .set_i(strobe(W_B_SET)), .clr_i(strobe(W_B_CLR)), .en_o(en_b));
  intc_mask_bank #(.W(BASE_W)) u_mask_base (
    .clk(clk), .rst(rst), .set_i(base_set_w[BASE_W-1:0]),
    .clr_i(base_clr_w[BASE_W-1:0]), .en_o(en_base));

  assign pend_a    = src_a & en_a;
  assign pend_b    = src_b & en_b;
  assign pend_base = src_base & en_base;

  intc_base_fmt #(.BANK_W(BANK_W), .BASE_W(BASE_W)) u_fmt (
    .pend_a(pend_a), .pend_b(pend_b), .pend_base(pend_base), .word_o(base_word));

  intc_fiq_route #(.NSRC(NSRC), .IDX_W(IDX_W)) u_route (
    .src_i({src_base, src_b, src_a}), .pend_i({pend_base, pend_b, pend_a}),
    .sel_i(fiq_sel), .on_i(fiq_on), .irq_d(irq_d), .fiq_d(fiq_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_sel <= '0;
      fiq_on  <= 1'b0;
    end else if (wr_en && widx == W_FIQ_CTL) begin
      fiq_sel <= wdata[IDX_W-1:0];
      fiq_on  <= wdata[IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
      rdata <= '0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
      if (rd_en) begin
        case (widx)
          W_BASE_PEND: rdata <= base_word;
          W_A_PEND:    rdata <= pend_a;
          W_B_PEND:    rdata <= pend_b;
          W_FIQ_CTL:   rdata <= BANK_W'({fiq_on, fiq_sel});
          W_A_SET:     rdata <= en_a;
          W_B_SET:     rdata <= en_b;
          W_BASE_SET:  rdata <= BANK_W'(en_base);
          default:     rdata <= '0;
        endcase
      end
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_a == '0 && en_b == '0 && en_base == '0 &&
                    !fiq_on && fiq_sel == '0 && !irq_o && !fiq_o));
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|base_word));
  // R9
  fiq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(fiq_on));
  // R5
  sum_b_chk: assert property (@(posedge clk) disable iff (rst)
    base_word[BASE_W+1] |-> (pend_b != '0));
endmodule

// File: tb/sim_banked_intc.sv
module sim_banked_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] src_a = '0, src_b = '0;
  logic [7:0]  src_base = '0;
  logic        irq_o, fiq_o;

  always #2ns clk = ~clk;

  banked_intc u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_a(src_a), .src_b(src_b), .src_base(src_base),
    .irq_o(irq_o), .fiq_o(fiq_o));

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare each completed read against the queued expectation
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pins(input logic ei, input logic ef, input string t);
    repeat (2) @(negedge clk);
    total++;
    if (irq_o !== ei || fiq_o !== ef) begin
      bad++;
      $display("FAIL %s: irq/fiq=%b%b expected=%b%b", t, irq_o, fiq_o, ei, ef);
    end
  endtask

  task automatic srcs(input logic [31:0] a, input logic [31:0] b, input logic [7:0] s);
    @(negedge clk); src_a = a; src_b = b; src_base = s;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(6'h0c, 32'h0, "R1 fiq ctl");
    rd(6'h10, 32'h0, "R1 mask A");
    rd(6'h14, 32'h0, "R1 mask B");
    rd(6'h18, 32'h0, "R1 mask base");
    pins(1'b0, 1'b0, "R1 outputs");
    // R2 write-one-to-set
    wr(6'h10, 32'h3);
    rd(6'h10, 32'h3, "R2 set A");
    wr(6'h10, 32'h4);
    rd(6'h10, 32'h7, "R2 zeros keep");
    // R3 write-one-to-clear
    wr(6'h1c, 32'h2);
    rd(6'h10, 32'h5, "R3 clear A");
    // R4 / R5 / R8 bank pending and summary
    srcs(32'h3, 32'h0, 8'h0);
    rd(6'h04, 32'h1, "R4 pend A");
    rd(6'h00, 32'h100, "R5 summary A");
    pins(1'b1, 1'b0, "R8 irq high");
    srcs(32'h2, 32'h0, 8'h0);
    rd(6'h04, 32'h0, "R4 unlatched");
    rd(6'h00, 32'h0, "R5 summary gone");
    pins(1'b0, 1'b0, "R8 irq low");
    // R6 shortcuts
    wr(6'h10, 32'h80);
    wr(6'h14, 32'h0200_0000);
    srcs(32'h80, 32'h0200_0000, 8'h0);
    rd(6'h04, 32'h80, "R6 bank A bit");
    rd(6'h08, 32'h0200_0000, "R6 bank B bit");
    rd(6'h00, 32'h0008_0400, "R6 shortcut only");
    srcs(32'h81, 32'h0200_0000, 8'h0);
    rd(6'h00, 32'h0008_0500, "R5 summary plus shortcut");
    // R7 base mask ignores upper bits
    wr(6'h1c, 32'h80);
    srcs(32'h80, 32'h0, 8'h0);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, 32'hFF, "R7 base mask width");
    rd(6'h00, 32'h0, "R7 shortcut stays masked");
    wr(6'h24, 32'hFFFF_FF00);
    rd(6'h18, 32'hFF, "R7 base clear upper");
    srcs(32'h0, 32'h0, 8'h10);
    rd(6'h00, 32'h10, "R5 base own bit");
    // R9 / R10 fast channel
    srcs(32'h0, 32'h0200_0000, 8'h0);
    wr(6'h0c, 32'hB9);
    rd(6'h0c, 32'hB9, "R9 ctl readback");
    pins(1'b0, 1'b1, "R10 steered off irq");
    srcs(32'h1, 32'h0200_0000, 8'h0);
    pins(1'b1, 1'b1, "R10 other line irq");
    wr(6'h0c, 32'hC3);
    srcs(32'h0, 32'h0, 8'h08);
    pins(1'b0, 1'b1, "R9 base index");
    wr(6'h0c, 32'h43);
    pins(1'b1, 1'b0, "R9 channel off");
    wr(6'h0c, 32'h85);
    srcs(32'h20, 32'h0, 8'h0);
    pins(1'b0, 1'b1, "R9 raw level");
    wr(6'h0c, 32'hE4);
    pins(1'b0, 1'b0, "R9 index out of range");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule